// File: doc/BRIEF.md
# Base and Limit Address Relocation Unit

This block sits between a processor's memory request port and physical memory. It gives a program a virtual address space that begins at zero and maps it onto one contiguous window of physical memory. The window is described by two registers: a base, which is the physical address where the window starts, and a limit, which is the number of addressable bytes in the window.

Software writes the two registers through a small configuration port while translation is switched off. In that unmapped mode every processor request goes to memory with its address unchanged. Once translation is switched on, each request's address is first compared against the limit. An address inside the window is relocated by adding the base and then forwarded. An address outside the window is never forwarded: the unit raises a one-cycle fault pulse and keeps the offending virtual address for software to read. To run a different program, software switches translation off, loads a new base and limit, and switches it back on.

Every request leaves through a register stage, so a request presented before a clock edge appears on the physical side, or produces its fault, just after that edge.

Top module: `addr_reloc_unit`

## Requirements
- R1: After reset, `mem_valid`, `mem_write`, `mem_addr`, `fault` and `fault_vaddr` are all zero, and the base and limit registers are zero, so every translated request faults until the limit is loaded.
- R2: While `map_en` is 0, a cycle with `cfg_we`=1 loads `cfg_wdata` into the base register when `cfg_sel`=0 and into the limit register when `cfg_sel`=1. A new value governs requests from the next cycle onwards.
- R3: With `map_en`=0, a request with `cpu_valid`=1 at a clock edge appears after that edge as `mem_valid`=1, `mem_addr`=`cpu_addr` and `mem_write`=`cpu_write`.
- R4: With `map_en`=1 and `cpu_addr` below the limit, the request appears one cycle later with `mem_addr` = (base + `cpu_addr`) mod 2^`PA_W` and `mem_write`=`cpu_write`.
- R5: With `map_en`=1 and `cpu_addr` >= limit, `mem_valid` stays 0 and `fault` is 1 for exactly the following cycle.
- R6: The limit is exclusive: address limit-1 is forwarded, and address equal to the limit faults.
- R7: Configuration writes in a cycle with `map_en`=1 have no effect on either register, which shows in the translations that follow.
- R8: On every fault `fault_vaddr` takes the faulting virtual address, and it keeps that value until the next fault.
- R9: After translation is switched off, both registers reloaded and translation switched on again, requests follow the new window.
- R10: A cycle with `cpu_valid`=0 yields `mem_valid`=0 and `fault`=0 in the next cycle, and `mem_addr`/`mem_write` read zero whenever `mem_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Register select: 0 base, 1 limit |
| cfg_wdata | input | PA_W | Configuration write data |
| map_en | input | 1 | 1 = translate and check, 0 = pass through |
| cpu_valid | input | 1 | Processor request valid |
| cpu_write | input | 1 | Processor request is a write |
| cpu_addr | input | PA_W | Processor address |
| mem_valid | output | 1 | Physical request valid |
| mem_write | output | 1 | Physical request is a write |
| mem_addr | output | PA_W | Physical address |
| fault | output | 1 | One-cycle protection fault pulse |
| fault_vaddr | output | PA_W | Virtual address of the most recent fault |

## Verification
The bench builds the unit with `PA_W` set to 12, so the physical space is only 4096 bytes. At that width a window placed near the top of memory makes the base-plus-address sum wrap, which brings the modulo behaviour of R4 within reach, and the limit edge of R6 can be hit with exact values on both sides. The reference model tracks base, limit and the captured fault address as plain integers and compares all five outputs every cycle, including cycles where configuration writes are attempted with translation on.

// File: rtl/reloc_pkg.sv
package reloc_pkg;

  typedef enum logic {
    SEL_BASE  = 1'b0,
    SEL_LIMIT = 1'b1
  } reloc_sel_e;

endpackage

// File: rtl/reloc_regs.sv
module reloc_regs
  import reloc_pkg::*;
#(
  parameter int PA_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  reloc_sel_e      cfg_sel,
  input  logic [PA_W-1:0] cfg_wdata,
  input  logic            map_en,
  output logic [PA_W-1:0] base_o,
  output logic [PA_W-1:0] limit_o
);

  logic [PA_W-1:0] base_q;
  logic [PA_W-1:0] limit_q;
  logic            wr_ok;

  // Writes are accepted only while translation is off
  assign wr_ok = cfg_we && !map_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      limit_q <= '0;
    end else if (wr_ok) begin
      if (cfg_sel == SEL_BASE) base_q  <= cfg_wdata;
      else                     limit_q <= cfg_wdata;
    end
  end

  assign base_o  = base_q;
  assign limit_o = limit_q;

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (rst)
    map_en |=> ($stable(base_q) && $stable(limit_q))); // R7

  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !map_en && cfg_sel == SEL_LIMIT) |=> (limit_q == $past(cfg_wdata))); // R2

endmodule

// File: rtl/reloc_xlate.sv
module reloc_xlate #(
  parameter int PA_W = 32
) (
  input  logic            map_en,
  input  logic            cpu_valid,
  input  logic            cpu_write,
  input  logic [PA_W-1:0] cpu_addr,
  input  logic [PA_W-1:0] base_i,
  input  logic [PA_W-1:0] limit_i,
  output logic            fwd_valid,
  output logic            fwd_write,
  output logic [PA_W-1:0] fwd_addr,
  output logic            viol
);

  logic            out_of_range;
  logic [PA_W-1:0] reloc_sum;

  // Range test works on the raw virtual address, before the adder
  assign out_of_range = (cpu_addr >= limit_i);
  assign reloc_sum    = base_i + cpu_addr;

  always_comb begin
    viol      = 1'b0;
    fwd_valid = 1'b0;
    fwd_write = 1'b0;
    fwd_addr  = '0;
    if (cpu_valid) begin
      if (!map_en) begin
        fwd_valid = 1'b1;
        fwd_write = cpu_write;
        fwd_addr  = cpu_addr;
      end else if (out_of_range) begin
        viol = 1'b1;
      end else begin
        fwd_valid = 1'b1;
        fwd_write = cpu_write;
        fwd_addr  = reloc_sum;
      end
    end
  end

  always_comb begin
    if (viol && fwd_valid) assert (0) else ; // R5 never both
    AST_EXCL: assert (!(viol && fwd_valid)); // R5
  end

endmodule

// File: rtl/reloc_outstage.sv
module reloc_outstage #(
  parameter int PA_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fwd_valid,
  input  logic            fwd_write,
  input  logic [PA_W-1:0] fwd_addr,
  input  logic            viol,
  input  logic [PA_W-1:0] viol_vaddr,
  output logic            mem_valid,
  output logic            mem_write,
  output logic [PA_W-1:0] mem_addr,
  output logic            fault,
  output logic [PA_W-1:0] fault_vaddr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_valid   <= 1'b0;
      mem_write   <= 1'b0;
      mem_addr    <= '0;
      fault       <= 1'b0;
      fault_vaddr <= '0;
    end else begin
      mem_valid <= fwd_valid;
      mem_write <= fwd_write;
      mem_addr  <= fwd_addr;
      fault     <= viol;
      if (viol) fault_vaddr <= viol_vaddr;
    end
  end

  AST_FAULT_VADDR: assert property (@(posedge clk) disable iff (rst)
    viol |=> (fault_vaddr == $past(viol_vaddr))); // R8

  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !viol |=> $stable(fault_vaddr)); // R8

endmodule

// File: rtl/addr_reloc_unit.sv
module addr_reloc_unit
  import reloc_pkg::*;
#(
  parameter int PA_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic            cfg_sel,
  input  logic [PA_W-1:0] cfg_wdata,
  input  logic            map_en,
  input  logic            cpu_valid,
  input  logic            cpu_write,
  input  logic [PA_W-1:0] cpu_addr,
  output logic            mem_valid,
  output logic            mem_write,
  output logic [PA_W-1:0] mem_addr,
  output logic            fault,
  output logic [PA_W-1:0] fault_vaddr
);

  logic [PA_W-1:0] base_w;
  logic [PA_W-1:0] limit_w;
  logic            fwd_valid;
  logic            fwd_write;
  logic [PA_W-1:0] fwd_addr;
  logic            viol;
  reloc_sel_e      sel_e;

  assign sel_e = reloc_sel_e'(cfg_sel);

  reloc_regs #(.PA_W(PA_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_sel   (sel_e),
    .cfg_wdata (cfg_wdata),
    .map_en    (map_en),
    .base_o    (base_w),
    .limit_o   (limit_w)
  );

  reloc_xlate #(.PA_W(PA_W)) u_xlate (
    .map_en    (map_en),
    .cpu_valid (cpu_valid),
    .cpu_write (cpu_write),
    .cpu_addr  (cpu_addr),
    .base_i    (base_w),
    .limit_i   (limit_w),
    .fwd_valid (fwd_valid),
    .fwd_write (fwd_write),
    .fwd_addr  (fwd_addr),
    .viol      (viol)
  );

  reloc_outstage #(.PA_W(PA_W)) u_out (
    .clk         (clk),
    .rst         (rst),
    .fwd_valid   (fwd_valid),
    .fwd_write   (fwd_write),
    .fwd_addr    (fwd_addr),
    .viol        (viol),
    .viol_vaddr  (cpu_addr),
    .mem_valid   (mem_valid),
    .mem_write   (mem_write),
    .mem_addr    (mem_addr),
    .fault       (fault),
    .fault_vaddr (fault_vaddr)
  );

  AST_REAL_PASS: assert property (@(posedge clk) disable iff (rst)
    (cpu_valid && !map_en) |=> (mem_valid && mem_addr == $past(cpu_addr))); // R3

  AST_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && $past(map_en)) |-> ($past(cpu_addr) < $past(limit_w))); // R5

  AST_FAULT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    fault |-> !mem_valid); // R5

  AST_FAULT_MAPPED: assert property (@(posedge clk) disable iff (rst)
    fault |-> ($past(map_en) && $past(cpu_valid))); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !cpu_valid |=> (!mem_valid && !fault)); // R10

endmodule

// File: tb/test_addr_reloc_unit.sv
module test_addr_reloc_unit;

  localparam int PA_W = 12;
  localparam int MASK = (1 << PA_W) - 1;

  logic            clk = 1'b0;
  logic            rst;
  logic            cfg_we;
  logic            cfg_sel;
  logic [PA_W-1:0] cfg_wdata;
  logic            map_en;
  logic            cpu_valid;
  logic            cpu_write;
  logic [PA_W-1:0] cpu_addr;
  logic            mem_valid;
  logic            mem_write;
  logic [PA_W-1:0] mem_addr;
  logic            fault;
  logic [PA_W-1:0] fault_vaddr;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // reference state
  int m_base = 0, m_limit = 0, m_fva = 0;
  int e_mv = 0, e_mw = 0, e_ma = 0, e_f = 0;

  always #10 clk = ~clk;

  addr_reloc_unit #(.PA_W(PA_W)) i_addr_reloc_unit (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .map_en(map_en), .cpu_valid(cpu_valid),
    .cpu_write(cpu_write), .cpu_addr(cpu_addr), .mem_valid(mem_valid),
    .mem_write(mem_write), .mem_addr(mem_addr), .fault(fault),
    .fault_vaddr(fault_vaddr)
  );

  task automatic compare(input string tag);
    vectors++;
    if (mem_valid !== e_mv[0] || mem_write !== e_mw[0] || int'(mem_addr) != e_ma ||
        fault !== e_f[0] || int'(fault_vaddr) != m_fva) begin
      miscompares++;
      $display("FAIL %s: got v=%0d w=%0d a=%h f=%0d fva=%h, expected v=%0d w=%0d a=%h f=%0d fva=%h",
               tag, mem_valid, mem_write, mem_addr, fault, fault_vaddr,
               e_mv, e_mw, e_ma, e_f, m_fva);
    end
  endtask

  task automatic step(input bit we, input bit sel, input int wd, input bit en,
                      input bit v, input bit w, input int a, input string tag);
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd[PA_W-1:0];
    map_en = en; cpu_valid = v; cpu_write = w; cpu_addr = a[PA_W-1:0];
    @(posedge clk);
    e_mv = 0; e_mw = 0; e_ma = 0; e_f = 0;
    if (v && !en) begin
      e_mv = 1; e_mw = w; e_ma = a;
    end else if (v && en) begin
      if (a >= m_limit) begin
        e_f = 1; m_fva = a;
      end else begin
        e_mv = 1; e_mw = w; e_ma = (m_base + a) & MASK;
      end
    end
    if (we && !en) begin
      if (sel) m_limit = wd; else m_base = wd;
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst = 1; cfg_we = 0; cfg_sel = 0; cfg_wdata = '0; map_en = 0;
    cpu_valid = 0; cpu_write = 0; cpu_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    compare("R1 reset state");
    // R1: limit zero after reset, so mapped address 0 faults
    step(0,0,0, 1, 1,0,'h000, "R1 unloaded limit faults");
    // R3 real mode pass-through
    step(0,0,0, 0, 1,0,'h123, "R3 real read");
    step(0,0,0, 0, 1,1,'hFFF, "R3 real write");
    step(0,0,0, 0, 0,0,'h555, "R10 idle");
    // R2 load base and limit with translation off
    step(1,0,'h300, 0, 1,0,'h040, "R2 load base");
    step(1,1,'h100, 0, 0,0,0, "R2 load limit");
    // R4 mapped in-range
    step(0,0,0, 1, 1,0,'h000, "R4 mapped zero");
    step(0,0,0, 1, 1,1,'h050, "R4 mapped write");
    // R6 boundaries
    step(0,0,0, 1, 1,0,'h0FF, "R6 limit-1 forwarded");
    step(0,0,0, 1, 1,0,'h100, "R6 limit faults");
    step(0,0,0, 1, 0,0,0, "R5 fault single cycle");
    step(0,0,0, 1, 1,1,'hFFF, "R5 far fault");
    step(0,0,0, 1, 1,0,'h010, "R8 fault addr held");
    // R7 writes while mapped are ignored
    step(1,0,'h500, 1, 0,0,0, "R7 base write ignored");
    step(1,1,'h800, 1, 1,0,'h020, "R7 limit write ignored");
    step(0,0,0, 1, 1,0,'h0FF, "R7 old window kept");
    step(0,0,0, 1, 1,0,'h200, "R7 old limit enforced");
    // R9 switch address space, window near top so sum wraps
    step(0,0,0, 0, 0,0,0, "R9 disable");
    step(1,0,'hF80, 0, 0,0,0, "R9 reload base");
    step(1,1,'h200, 0, 0,0,0, "R9 reload limit");
    step(0,0,0, 1, 1,0,'h07F, "R9 new base");
    step(0,0,0, 1, 1,1,'h090, "R4 wrap sum");
    step(0,0,0, 1, 1,0,'h1FF, "R6 new limit-1");
    step(0,0,0, 1, 1,0,'h200, "R6 new limit faults");
    step(0,0,0, 1, 0,0,0, "R10 idle mapped");
    // back to real mode
    step(0,0,0, 0, 1,0,'h7AB, "R3 real after map");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule